// File: doc/BRIEF.md
# Program Counter Sequencer with Return Stack

This block holds the 13-bit program counter of a small controller whose program store is 8192 words. Each cycle it picks one next PC. The choices are: stay put, advance by one, enter an interrupt at its fixed vector, take a short call into one of sixteen fixed slots, take a long call into the low 2K words, or return to a saved address. Decode logic outside the block supplies these requests as strobes.

Calls and interrupt entries share a 13-level hardware return stack. Each push saves the address of the next sequential instruction. Software can preset the stack pointer to any level, so that nesting starts there. Two sticky flags record a push onto a full stack and a return from an empty one. Only reset clears them.

Top module: `pc_stack_unit`

## Requirements
- R1: While rst_ni is low, and after its release until the first event, pc_o is 0, sp_o is 0, and ovf_o and unf_o are 0.
- R2: With step_i high and no other event, pc_o increases by one on the next edge. It wraps from 1FFFh to 0.
- R3: If any bit of irq_i is set, the lowest set bit k wins (bit 0 external, 1 fast timer, 2 timer A, 3 timer B, 4 time base, 5 speech end). pc_o becomes 2·(k+1), that is 002h..00Ch, and the current pc_o+1 is pushed.
- R4: call_i with call_long_i=0 is a short call. pc_o becomes 00Eh + 8·call_arg_i[3:0], so the slots run 00Eh..086h. call_arg_i[10:4] has no effect. pc_o+1 is pushed.
- R5: call_i with call_long_i=1 is a long call. pc_o becomes {2'b00, call_arg_i[10:0]}, and pc_o+1 is pushed.
- R6: A push stores its value at level sp_o, then sp_o increases by one. ret_i with sp_o>0 decreases sp_o first and loads pc_o from that level, so returns come back in LIFO order.
- R7: sp_we_i loads sp_o from sp_wdata_i when the value is 0..13 and the cycle has no push and no pop. Values 14 and 15, and writes in a push or pop cycle, leave sp_o unchanged.
- R8: A push while sp_o is 13 stores nothing and leaves sp_o at 13. It sets ovf_o, which stays set until reset. pc_o still moves to the call or vector target.
- R9: ret_i with sp_o=0 leaves pc_o and sp_o unchanged. It sets unf_o, which stays set until reset.
- R10: Events rank as follows: interrupt, then call, then return, then step. Lower-ranked strobes in the same cycle have no effect on pc_o or sp_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Advance to the next sequential word |
| call_i | input | 1 | Call request |
| call_long_i | input | 1 | 1: long call, 0: short slot call |
| call_arg_i | input | 11 | Call operand (slot index in bits 3:0, or target address) |
| irq_i | input | 6 | Pending interrupt requests, one per source |
| ret_i | input | 1 | Return request |
| sp_we_i | input | 1 | Stack pointer write strobe |
| sp_wdata_i | input | 4 | Stack pointer write value |
| pc_o | output | 13 | Program counter |
| sp_o | output | 4 | Stack pointer (number of saved levels) |
| ovf_o | output | 1 | Sticky stack overflow flag |
| unf_o | output | 1 | Sticky stack underflow flag |

## Verification
The hardest state to reach from the ports is a full stack. Reaching it requires thirteen nested pushes with distinct return addresses, then a fourteenth push, and the overflow and its dropped save must then be told apart from a corrupted entry. The bench reaches it with thirteen long calls to distinct addresses, so that every saved value is unique. It then pushes once more through an interrupt and unwinds all thirteen levels, checking each return address in turn. A further return then drives the underflow. The same full state is reached a second time by presetting the pointer, which exercises the interaction between the overflow and a software-loaded pointer.

// File: rtl/psu_pkg.sv
package psu_pkg;
  typedef enum logic [2:0] {
    EV_HOLD,
    EV_IRQ,
    EV_CALL,
    EV_RET,
    EV_STEP
  } pc_ev_e;
endpackage

// File: rtl/psu_target.sv
module psu_target #(
  parameter int PCW          = 13,
  parameter int NSRC         = 6,
  parameter int LCW          = 11,
  parameter int SHORT_N      = 16,
  parameter int SHORT_BASE   = 14,
  parameter int SHORT_STRIDE = 8,
  parameter int VEC_BASE     = 2,
  parameter int VEC_STRIDE   = 2
) (
  input  logic [NSRC-1:0] irq_i,
  input  logic            call_long_i,
  input  logic [LCW-1:0]  call_arg_i,
  output logic            irq_hit_o,
  output logic [PCW-1:0]  irq_tgt_o,
  output logic [PCW-1:0]  call_tgt_o
);
  localparam int SIW = $clog2(SHORT_N);

  logic [PCW-1:0] short_tgt;
  logic [PCW-1:0] long_tgt;

  // lowest source index wins: scan downward so the last hit is the lowest
  always_comb begin
    irq_hit_o = 1'b0;
    irq_tgt_o = '0;
    for (int k = NSRC - 1; k >= 0; k--) begin
      if (irq_i[k]) begin
        irq_hit_o = 1'b1;
        irq_tgt_o = PCW'(VEC_BASE + VEC_STRIDE * k);
      end
    end
  end

  assign short_tgt  = PCW'(SHORT_BASE) + PCW'(call_arg_i[SIW-1:0]) * PCW'(SHORT_STRIDE);
  assign long_tgt   = PCW'(call_arg_i);
  assign call_tgt_o = call_long_i ? long_tgt : short_tgt;

  // R3
  always_comb begin
    if (irq_hit_o) begin
      irq_vec_range_chk: assert (irq_tgt_o >= PCW'(VEC_BASE) &&
                                 irq_tgt_o <= PCW'(VEC_BASE + VEC_STRIDE * (NSRC - 1)));
    end
  end
endmodule

// File: rtl/psu_ret_stack.sv
module psu_ret_stack #(
  parameter int   PCW   = 13,
  parameter int   DEPTH = 13,
  localparam int  SPW   = $clog2(DEPTH + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           push_i,
  input  logic           pop_i,
  input  logic [PCW-1:0] push_data_i,
  input  logic           sp_we_i,
  input  logic [SPW-1:0] sp_wdata_i,
  output logic [SPW-1:0] sp_o,
  output logic [PCW-1:0] top_o,
  output logic           full_o,
  output logic           empty_o,
  output logic           ovf_o,
  output logic           unf_o
);
  localparam int MEMN = 2 ** SPW;

  logic [PCW-1:0] mem_q [MEMN];
  logic [SPW-1:0] sp_q;
  logic [SPW-1:0] sp_dec;
  logic           do_push;
  logic           do_pop;
  logic           wr_ok;

  assign full_o  = (sp_q == SPW'(DEPTH));
  assign empty_o = (sp_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign wr_ok   = sp_we_i && !push_i && !pop_i && (sp_wdata_i <= SPW'(DEPTH));
  assign sp_dec  = sp_q - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q  <= '0;
      ovf_o <= 1'b0;
      unf_o <= 1'b0;
    end else begin
      if (do_push)     sp_q <= sp_q + 1'b1;
      else if (do_pop) sp_q <= sp_dec;
      else if (wr_ok)  sp_q <= sp_wdata_i;
      if (push_i && full_o) ovf_o <= 1'b1;
      if (pop_i && empty_o) unf_o <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[sp_q] <= push_data_i;
  end

  assign top_o = mem_q[sp_dec];
  assign sp_o  = sp_q;

  // R7
  sp_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_q <= SPW'(DEPTH));

  // R8
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);

  // R9
  unf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_o |=> unf_o);

  // R6
  push_grows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !full_o) |=> sp_q == $past(sp_q) + 1'b1);

  // R8
  full_push_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o) |=> (ovf_o && sp_q == SPW'(DEPTH)));
endmodule

// File: rtl/pc_stack_unit.sv
module pc_stack_unit #(
  parameter int  PCW   = 13,
  parameter int  DEPTH = 13,
  parameter int  NSRC  = 6,
  parameter int  LCW   = 11,
  localparam int SPW   = $clog2(DEPTH + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            step_i,
  input  logic            call_i,
  input  logic            call_long_i,
  input  logic [LCW-1:0]  call_arg_i,
  input  logic [NSRC-1:0] irq_i,
  input  logic            ret_i,
  input  logic            sp_we_i,
  input  logic [SPW-1:0]  sp_wdata_i,
  output logic [PCW-1:0]  pc_o,
  output logic [SPW-1:0]  sp_o,
  output logic            ovf_o,
  output logic            unf_o
);
  import psu_pkg::*;

  pc_ev_e         ev;
  logic [PCW-1:0] pc_q;
  logic [PCW-1:0] pc_nxt;
  logic [PCW-1:0] pc_inc;
  logic           irq_hit;
  logic [PCW-1:0] irq_tgt;
  logic [PCW-1:0] call_tgt;
  logic [PCW-1:0] stk_top;
  logic           stk_full;
  logic           stk_empty;
  logic           push;
  logic           pop;

  psu_target #(.PCW(PCW), .NSRC(NSRC), .LCW(LCW)) u_target (
    .irq_i       (irq_i),
    .call_long_i (call_long_i),
    .call_arg_i  (call_arg_i),
    .irq_hit_o   (irq_hit),
    .irq_tgt_o   (irq_tgt),
    .call_tgt_o  (call_tgt)
  );

  always_comb begin
    if (irq_hit)     ev = EV_IRQ;
    else if (call_i) ev = EV_CALL;
    else if (ret_i)  ev = EV_RET;
    else if (step_i) ev = EV_STEP;
    else             ev = EV_HOLD;
  end

  assign push   = (ev == EV_IRQ) || (ev == EV_CALL);
  assign pop    = (ev == EV_RET);
  assign pc_inc = pc_q + 1'b1;

  always_comb begin
    unique case (ev)
      EV_IRQ:  pc_nxt = irq_tgt;
      EV_CALL: pc_nxt = call_tgt;
      EV_RET:  pc_nxt = stk_empty ? pc_q : stk_top;
      EV_STEP: pc_nxt = pc_inc;
      default: pc_nxt = pc_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_nxt;
  end

  psu_ret_stack #(.PCW(PCW), .DEPTH(DEPTH)) u_stack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .pop_i       (pop),
    .push_data_i (pc_inc),
    .sp_we_i     (sp_we_i),
    .sp_wdata_i  (sp_wdata_i),
    .sp_o        (sp_o),
    .top_o       (stk_top),
    .full_o      (stk_full),
    .empty_o     (stk_empty),
    .ovf_o       (ovf_o),
    .unf_o       (unf_o)
  );

  assign pc_o = pc_q;

  // R3
  irq_vector_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|irq_i) |=> (pc_q[0] == 1'b0 && pc_q >= PCW'(2) && pc_q <= PCW'(2 * NSRC)));

  // R5
  long_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_i && call_long_i && !(|irq_i)) |=> pc_q < PCW'(2 ** LCW));

  // R9
  unf_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && !call_i && !(|irq_i) && sp_o == '0) |=> ($stable(pc_q) && unf_o));

  // R2
  step_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !ret_i && !call_i && !(|irq_i)) |=> pc_q == $past(pc_q) + 1'b1);

  // R8
  full_still_jumps_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stk_full && call_i && !(|irq_i)) |=> pc_q == $past(call_tgt));
endmodule

// File: tb/sim_pc_stack_unit.sv
module sim_pc_stack_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        step_i = 1'b0, call_i = 1'b0, call_long_i = 1'b0, ret_i = 1'b0, sp_we_i = 1'b0;
  logic [10:0] call_arg_i = '0;
  logic [5:0]  irq_i = '0;
  logic [3:0]  sp_wdata_i = '0;
  logic [12:0] pc_o;
  logic [3:0]  sp_o;
  logic        ovf_o, unf_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int m_pc, m_sp, m_ovf, m_unf;
  int m_stk [16];

  always #5 clk_i = ~clk_i;

  pc_stack_unit u0 (.*);

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(string tag);
    chk(tag, "pc", int'(pc_o), m_pc);
    chk(tag, "sp", int'(sp_o), m_sp);
    chk(tag, "ovf", int'(ovf_o), m_ovf);
    chk(tag, "unf", int'(unf_o), m_unf);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    m_pc = 0; m_sp = 0; m_ovf = 0; m_unf = 0;
    @(negedge clk_i);
    chk_all("R1");
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_all("R1");
  endtask

  // drive one cycle at negedge, update the model, check at the next negedge
  task automatic cyc(string tag, bit st, bit cl, bit lg, int arg, bit rt,
                     int irq, bit we, int wd);
    int  push, pop, tgt;
    step_i = st; call_i = cl; call_long_i = lg; call_arg_i = 11'(arg);
    ret_i = rt; irq_i = 6'(irq); sp_we_i = we; sp_wdata_i = 4'(wd);
    push = 0; pop = 0; tgt = m_pc;
    if (irq != 0) begin
      for (int k = 5; k >= 0; k--) if (irq[k]) tgt = 2 * (k + 1);
      push = 1;
    end else if (cl) begin
      tgt = lg ? (arg & 'h7FF) : ('h0E + 8 * (arg & 'hF));
      push = 1;
    end else if (rt) begin
      if (m_sp == 0) m_unf = 1;
      else pop = 1;
    end else if (st) begin
      tgt = (m_pc + 1) % 8192;
    end
    if (push != 0) begin
      if (m_sp == 13) m_ovf = 1;
      else begin
        m_stk[m_sp] = (m_pc + 1) % 8192;
        m_sp++;
      end
    end else if (pop != 0) begin
      m_sp--;
      tgt = m_stk[m_sp];
    end else if (we && wd <= 13) begin
      m_sp = wd;
    end
    m_pc = tgt;
    @(negedge clk_i);
    step_i = 0; call_i = 0; ret_i = 0; irq_i = '0; sp_we_i = 0;
    chk_all(tag);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    m_pc = 0; m_sp = 0; m_ovf = 0; m_unf = 0;
    for (int i = 0; i < 16; i++) m_stk[i] = 0;
    do_reset();

    // R2: full sweep of the address space and the wrap
    for (int i = 0; i < 8192; i++) cyc("R2", 1, 0, 0, 0, 0, 0, 0, 0);
    chk("R2", "wrap", int'(pc_o), 0);

    // R4: every short slot with junk in the upper operand bits
    for (int n = 0; n < 16; n++) begin
      cyc("R4", 0, 1, 0, ((n * 37 + 5) << 4) | n, 0, 0, 0, 0);
      cyc("R6", 1, 0, 0, 0, 1, 0, 0, 0);
    end

    // R5: long call across the low region
    for (int a = 0; a < 2048; a += 61) begin
      cyc("R5", 0, 1, 1, a, 0, 0, 0, 0);
      cyc("R6", 0, 0, 0, 0, 1, 0, 0, 0);
    end
    cyc("R5", 0, 1, 1, 'h7FF, 0, 0, 0, 0);
    cyc("R2", 1, 0, 0, 0, 0, 0, 0, 0);
    cyc("R6", 0, 0, 0, 0, 1, 0, 0, 0);

    // R3 and R10: every request pattern, with lower-ranked strobes present
    for (int p = 1; p < 64; p++) begin
      cyc("R3", p[0], p[1], p[2], p * 29, p[3], p, 1, 2);
      cyc("R6", 1, 0, 0, 0, 1, 0, 0, 0);
    end
    // R10: call beats return and step, return beats step
    cyc("R10", 1, 1, 0, 3, 1, 0, 0, 0);
    cyc("R10", 1, 0, 0, 0, 1, 0, 0, 0);

    // R6 and R8: fill all levels, one extra push, unwind in LIFO order
    for (int i = 0; i < 13; i++) cyc("R6", 0, 1, 1, 100 + 50 * i, 0, 0, 0, 0);
    cyc("R8", 0, 1, 0, 5, 0, 'h10, 0, 0);
    cyc("R8", 0, 1, 1, 7, 0, 0, 0, 0);
    for (int i = 0; i < 13; i++) cyc("R6", 0, 0, 0, 0, 1, 0, 0, 0);
    // R9: return from an empty stack
    cyc("R9", 0, 0, 0, 0, 1, 0, 0, 0);
    cyc("R9", 1, 0, 0, 0, 0, 0, 0, 0);

    // R7: every write value, plus writes in push and pop cycles
    for (int v = 0; v < 16; v++) cyc("R7", 1, 0, 0, 0, 0, 0, 1, v);
    cyc("R7", 0, 0, 0, 0, 0, 0, 1, 12);
    cyc("R7", 0, 1, 0, 9, 0, 0, 1, 3);
    cyc("R7", 0, 0, 0, 0, 1, 0, 1, 1);
    cyc("R7", 0, 0, 0, 0, 0, 0, 1, 13);
    cyc("R8", 0, 0, 0, 0, 0, 'h04, 0, 0);

    // R1: reset clears flags and pointer after use
    do_reset();
    cyc("R1", 0, 0, 0, 0, 0, 0, 0, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule